// File: doc/BRIEF.md
# Strobe-Captured Host Register Write Port

This block lets a host load a synthesizer's tuning registers over a parallel bus without sharing its clock. The host places a 16-bit word and a 3-bit destination code on the bus and pulses a write strobe. On the strobe's rising edge the word and the code are held in strobe-domain flops, and a single toggle flop changes state. That toggle crosses into the master clock domain through a synchronizer chain. An edge detector on the chain's output then produces a one-cycle commit pulse, and the pulse loads the held word into the selected destination.

There are eight destinations: the low and high halves of two 32-bit frequency words, and four 12-bit phase words. A `busy` output stays high from the strobe edge until the commit has landed. The host must not strobe again while `busy` is high. An active-low reset clears every destination. Because the held word cannot change before its commit, a strobe edge that lands on a master clock edge only shifts the commit by one cycle. It never damages the data.

Top module: `hwp_write_port`

## Requirements
- R1: The word and the destination code written are the ones present at the strobe's rising edge. Changes on `wr_data` or `wr_addr` after that edge have no effect on the value committed.
- R2: When the strobe rises strictly between two master clock edges, the destination keeps its old value through the second following `mclk` rising edge. It shows the new value after the third following edge (default two-stage synchronizer).
- R3: When the strobe rise coincides with an `mclk` rising edge, the new value appears after the second or the third following edge. By the third it is present and equal to the written word.
- R4: Destination codes 0, 1, 2 and 3 load `freq0[15:0]`, `freq0[31:16]`, `freq1[15:0]` and `freq1[31:16]` respectively, with all 16 data bits.
- R5: Destination codes 4, 5, 6 and 7 load phase word 0, 1, 2 and 3. Phase word k sits at `phase_bus[12k+11:12k]` and receives `wr_data[11:0]`. Bits 15:12 of the data are ignored.
- R6: A commit changes only the addressed destination. Without a commit, no destination changes.
- R7: `busy` is high from the strobe's rising edge until the master clock edge that commits the word, and low from then on.
- R8: While `rst_n` is low, all destinations read zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; commits happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_strobe | input | 1 | Host write strobe; data captured on its rising edge |
| wr_data | input | 16 | Host data bus |
| wr_addr | input | 3 | Destination code |
| busy | output | 1 | Write in flight; host must wait for it to fall |
| freq0 | output | 32 | Frequency word 0 |
| freq1 | output | 32 | Frequency word 1 |
| phase_bus | output | 48 | Four 12-bit phase words, word 0 in the low bits |

## Verification
Writes go to all eight destination codes with alternating, all-ones, single-bit and upper-nibble-set patterns. These show whether the decode puts each word in the right half or phase slot, and whether the phase slots drop the top four bits. Each strobe is followed right away by inverted data and a different code on the bus, so a design that samples the bus late instead of at the strobe edge is caught. Strobes placed mid-cycle are checked for the exact commit edge, together with the matching fall of `busy`. Strobes placed on a clock edge are checked only for a correct value within the allowed window. A full compare of every register on each quiet cycle exposes stray writes.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

   // Number of frequency words and halves per word; the destination code
   // layout puts frequency halves first, then the phase words.
   localparam int unsigned HWP_NUM_FREQ  = 2;
   localparam int unsigned HWP_HALVES    = 2;
   localparam int unsigned HWP_PHASE_BASE = HWP_NUM_FREQ * HWP_HALVES;

   // Slot index of half h of frequency word f.
   function automatic int unsigned hwp_freq_slot(input int unsigned f, input int unsigned h);
      return f * HWP_HALVES + h;
   endfunction

endpackage

// File: rtl/hwp_strobe_capture.sv
module hwp_strobe_capture #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] held_data,
   output logic [ADDR_W-1:0] held_addr,
   output logic              wr_toggle
);

   // Strobe-domain holding flops: the only state clocked by the host strobe.
   always_ff @(posedge wr_strobe or negedge rst_n) begin
      if (!rst_n) begin
         held_data <= '0;
         held_addr <= '0;
         wr_toggle <= 1'b0;
      end else begin
         held_data <= wr_data;
         held_addr <= wr_addr;
         wr_toggle <= ~wr_toggle;
      end
   end

endmodule

// File: rtl/hwp_toggle_sync.sv
module hwp_toggle_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic mclk,
   input  logic rst_n,
   input  logic toggle_in,
   output logic commit,
   output logic busy
);

   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   seen_q;

   // Synchronizer chain: stage 0 samples the strobe-domain toggle.
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge mclk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= toggle_in;
            end
         end else begin : g_next
            always_ff @(posedge mclk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   // Last toggle level already acted upon.
   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= chain_q[LAST];
   end

   assign commit = chain_q[LAST] ^ seen_q;
   assign busy   = toggle_in ^ seen_q;

endmodule

// File: rtl/hwp_reg_bank.sv
module hwp_reg_bank
   import hwp_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PHASE_W   = 12,
   parameter int unsigned NUM_PHASE = 4
) (
   input  logic                              mclk,
   input  logic                              rst_n,
   input  logic                              commit,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [HWP_NUM_FREQ*HWP_HALVES*DATA_W-1:0] freq_bus,
   output logic [NUM_PHASE*PHASE_W-1:0]      phase_bus
);

   // Frequency halves: slot f*2+h holds half h of word f.
   generate
      for (genvar f = 0; f < HWP_NUM_FREQ; f++) begin : g_freq
         for (genvar h = 0; h < HWP_HALVES; h++) begin : g_half
            localparam int unsigned SLOT = hwp_freq_slot(f, h);
            logic [DATA_W-1:0] half_q;
            always_ff @(posedge mclk or negedge rst_n) begin
               if (!rst_n)
                  half_q <= '0;
               else if (commit && (wr_addr == ADDR_W'(SLOT)))
                  half_q <= wr_data;
            end
            assign freq_bus[SLOT*DATA_W +: DATA_W] = half_q;
         end
      end
   endgenerate

   // Phase words follow the frequency slots; only the low PHASE_W bits load.
   generate
      for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase
         localparam int unsigned SLOT = HWP_PHASE_BASE + p;
         logic [PHASE_W-1:0] ph_q;
         always_ff @(posedge mclk or negedge rst_n) begin
            if (!rst_n)
               ph_q <= '0;
            else if (commit && (wr_addr == ADDR_W'(SLOT)))
               ph_q <= wr_data[PHASE_W-1:0];
         end
         assign phase_bus[p*PHASE_W +: PHASE_W] = ph_q;
      end
   endgenerate

endmodule

// File: rtl/hwp_write_port.sv
module hwp_write_port
   import hwp_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned PHASE_W     = 12,
   parameter int unsigned NUM_PHASE   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                         mclk,
   input  logic                         rst_n,
   input  logic                         wr_strobe,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            wr_addr,
   output logic                         busy,
   output logic [2*DATA_W-1:0]          freq0,
   output logic [2*DATA_W-1:0]          freq1,
   output logic [NUM_PHASE*PHASE_W-1:0] phase_bus
);

   localparam int unsigned FREQ_W  = HWP_HALVES * DATA_W;
   localparam int unsigned SLOTS   = HWP_PHASE_BASE + NUM_PHASE;

   // Elaboration-time parameter checks.
   if (SLOTS > (1 << ADDR_W)) begin : g_bad_addr
      $error("hwp_write_port: %0d destinations do not fit in ADDR_W=%0d", SLOTS, ADDR_W);
   end
   if (PHASE_W > DATA_W) begin : g_bad_phase
      $error("hwp_write_port: PHASE_W=%0d wider than DATA_W=%0d", PHASE_W, DATA_W);
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hwp_write_port: SYNC_STAGES=%0d below 2", SYNC_STAGES);
   end

   logic [DATA_W-1:0] held_data;
   logic [ADDR_W-1:0] held_addr;
   logic              wr_toggle;
   logic              commit;
   logic [HWP_NUM_FREQ*FREQ_W-1:0] freq_bus;

   hwp_strobe_capture #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_capture (
      .rst_n     (rst_n),
      .wr_strobe (wr_strobe),
      .wr_data   (wr_data),
      .wr_addr   (wr_addr),
      .held_data (held_data),
      .held_addr (held_addr),
      .wr_toggle (wr_toggle)
   );

   hwp_toggle_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .mclk      (mclk),
      .rst_n     (rst_n),
      .toggle_in (wr_toggle),
      .commit    (commit),
      .busy      (busy)
   );

   hwp_reg_bank #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .PHASE_W   (PHASE_W),
      .NUM_PHASE (NUM_PHASE)
   ) u_bank (
      .mclk      (mclk),
      .rst_n     (rst_n),
      .commit    (commit),
      .wr_addr   (held_addr),
      .wr_data   (held_data),
      .freq_bus  (freq_bus),
      .phase_bus (phase_bus)
   );

   assign freq0 = freq_bus[0      +: FREQ_W];
   assign freq1 = freq_bus[FREQ_W +: FREQ_W];

endmodule

// File: rtl/hwp_write_port_chk.sv
module hwp_write_port_chk #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PHASE_W   = 12,
   parameter int unsigned NUM_PHASE = 4
) (
   input logic                         mclk,
   input logic                         rst_n,
   input logic                         commit,
   input logic                         busy,
   input logic [ADDR_W-1:0]            cap_addr,
   input logic [DATA_W-1:0]            cap_data,
   input logic [2*DATA_W-1:0]          freq0,
   input logic [2*DATA_W-1:0]          freq1,
   input logic [NUM_PHASE*PHASE_W-1:0] phase_bus
);

   // R2: one strobe yields one commit pulse, never two in a row.
   a_r2_single_pulse: assert property (@(posedge mclk) disable iff (!rst_n)
      commit |=> !commit);

   // R4: code 0 loads the low half of frequency word 0 with the held word.
   a_r4_freq0_low: assert property (@(posedge mclk) disable iff (!rst_n)
      (commit && cap_addr == ADDR_W'(0)) |=> (freq0[DATA_W-1:0] == $past(cap_data)));

   // R4: code 3 loads the high half of frequency word 1.
   a_r4_freq1_high: assert property (@(posedge mclk) disable iff (!rst_n)
      (commit && cap_addr == ADDR_W'(3)) |=> (freq1[2*DATA_W-1:DATA_W] == $past(cap_data)));

   // R5: code 4 loads phase word 0 from the low data bits.
   a_r5_phase0: assert property (@(posedge mclk) disable iff (!rst_n)
      (commit && cap_addr == ADDR_W'(4)) |=> (phase_bus[PHASE_W-1:0] == $past(cap_data[PHASE_W-1:0])));

   // R6: frequency word 0 holds unless a commit targets code 0 or 1.
   a_r6_freq0_hold: assert property (@(posedge mclk) disable iff (!rst_n)
      !(commit && cap_addr < ADDR_W'(2)) |=> $stable(freq0));

   // R6: frequency word 1 holds unless a commit targets code 2 or 3.
   a_r6_freq1_hold: assert property (@(posedge mclk) disable iff (!rst_n)
      !(commit && (cap_addr == ADDR_W'(2) || cap_addr == ADDR_W'(3))) |=> $stable(freq1));

   // R6: phase words hold unless a commit targets code 4 or above.
   a_r6_phase_hold: assert property (@(posedge mclk) disable iff (!rst_n)
      !(commit && cap_addr >= ADDR_W'(4)) |=> $stable(phase_bus));

   // R8: reset state.
   always @(posedge mclk) begin
      if (!rst_n) begin
         a_r8_reset_clear: assert (freq0 == '0 && freq1 == '0 && phase_bus == '0 && !busy);
      end
   end

endmodule

bind hwp_write_port hwp_write_port_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .PHASE_W   (PHASE_W),
   .NUM_PHASE (NUM_PHASE)
) u_chk (
   .mclk      (mclk),
   .rst_n     (rst_n),
   .commit    (commit),
   .busy      (busy),
   .cap_addr  (held_addr),
   .cap_data  (held_data),
   .freq0     (freq0),
   .freq1     (freq1),
   .phase_bus (phase_bus)
);

// File: tb/hwp_write_port_bench.sv
module hwp_write_port_bench;

   localparam int CLK_PERIOD = 10;

   logic        mclk = 1'b0;
   logic        rst_n;
   logic        wr_strobe;
   logic [15:0] wr_data;
   logic [2:0]  wr_addr;
   logic        busy;
   logic [31:0] freq0, freq1;
   logic [47:0] phase_bus;

   hwp_write_port u_hwp_write_port (
      .mclk      (mclk),
      .rst_n     (rst_n),
      .wr_strobe (wr_strobe),
      .wr_data   (wr_data),
      .wr_addr   (wr_addr),
      .busy      (busy),
      .freq0     (freq0),
      .freq1     (freq1),
      .phase_bus (phase_bus)
   );

   always #(CLK_PERIOD/2) mclk = ~mclk;

   int cyc = 0;
   always @(posedge mclk) cyc <= cyc + 1;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // Reference model of the destinations.
   logic [31:0] m_f0 = '0, m_f1 = '0;
   logic [47:0] m_ph = '0;

   // Scoreboard queues (one entry per write in flight).
   logic [2:0]  q_addr[$];
   logic [15:0] q_data[$];
   int          q_stamp[$];
   bit          q_loose[$];
   string       q_tag[$];

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      check(freq0 == m_f0, req, 64'(freq0), 64'(m_f0));
      check(freq1 == m_f1, req, 64'(freq1), 64'(m_f1));
      check(phase_bus == m_ph, req, 64'(phase_bus), 64'(m_ph));
   endtask

   // R4/R5 map: 0..3 frequency halves, 4..7 phase words from data[11:0].
   task automatic apply(input logic [2:0] a, input logic [15:0] d);
      case (a)
         3'd0: m_f0[15:0]  = d;
         3'd1: m_f0[31:16] = d;
         3'd2: m_f1[15:0]  = d;
         3'd3: m_f1[31:16] = d;
         default: m_ph[(int'(a) - 4) * 12 +: 12] = d[11:0];
      endcase
   endtask

   // Monitor: pops expected writes at the cycle they must appear.
   always @(negedge mclk) begin
      if (rst_n && !done) begin
         if (q_addr.size() != 0) begin
            if (!q_loose[0] && cyc == q_stamp[0] + 2) begin
               compare_all("R2 (not yet committed)");
               check(busy == 1'b1, "R7 (busy while pending)", 64'(busy), 64'd1);
            end
            if (cyc == q_stamp[0] + 3) begin
               apply(q_addr[0], q_data[0]);
               compare_all(q_tag[0]);
               if (!q_loose[0])
                  check(busy == 1'b0, "R7 (busy cleared at commit)", 64'(busy), 64'd0);
               void'(q_addr.pop_front());
               void'(q_data.pop_front());
               void'(q_stamp.pop_front());
               void'(q_loose.pop_front());
               void'(q_tag.pop_front());
            end
         end else begin
            compare_all("R6 (idle hold)");
         end
      end
   end

   task automatic wait_idle();
      while (q_addr.size() != 0) @(negedge mclk);
   endtask

   // Strobe rises mid-cycle; bus is scrambled right after (R1).
   task automatic do_write(input logic [2:0] a, input logic [15:0] d, input string tag);
      wait_idle();
      @(negedge mclk);
      wr_addr = a;
      wr_data = d;
      #2 wr_strobe = 1'b1;
      q_addr.push_back(a); q_data.push_back(d); q_stamp.push_back(cyc);
      q_loose.push_back(1'b0); q_tag.push_back(tag);
      #2 wr_strobe = 1'b0;
      wr_data = ~d;
      wr_addr = a + 3'd1;
   endtask

   // Strobe rises on the mclk edge itself (R3).
   task automatic do_write_edge(input logic [2:0] a, input logic [15:0] d, input string tag);
      wait_idle();
      @(negedge mclk);
      wr_addr = a;
      wr_data = d;
      @(posedge mclk);
      wr_strobe = 1'b1;
      #1;
      q_addr.push_back(a); q_data.push_back(d); q_stamp.push_back(cyc);
      q_loose.push_back(1'b1); q_tag.push_back(tag);
      #2 wr_strobe = 1'b0;
      wr_data = ~d;
      wr_addr = a + 3'd2;
   endtask

   initial begin
      rst_n     = 1'b1;
      wr_strobe = 1'b0;
      wr_data   = '0;
      wr_addr   = '0;
      #1 rst_n  = 1'b0;
      repeat (3) @(negedge mclk);
      compare_all("R8 (reset state)");
      check(busy == 1'b0, "R8 (busy in reset)", 64'(busy), 64'd0);
      rst_n = 1'b1;

      do_write(3'd0, 16'hA5A5, "R4 code0");
      do_write(3'd1, 16'h5A5A, "R4 code1");
      do_write(3'd2, 16'hFFFF, "R4 code2");
      do_write(3'd3, 16'h0001, "R4 code3");
      do_write(3'd4, 16'hF123, "R5 phase0");
      do_write(3'd5, 16'h8ABC, "R5 phase1");
      do_write(3'd6, 16'h7FFF, "R5 phase2");
      do_write(3'd7, 16'hC000, "R5 phase3 upper bits dropped");
      do_write(3'd0, 16'h1357, "R1 overwrite with scrambled bus");
      do_write(3'd3, 16'h8000, "R6 single half");
      for (int i = 0; i < 4; i++)
         do_write(3'(i), 16'(16'h1 << (i * 4)), "R2 walking one");
      do_write_edge(3'd1, 16'h2468, "R3 coincident edge");
      do_write_edge(3'd6, 16'h0F0F, "R3 coincident edge");
      do_write_edge(3'd2, 16'h0000, "R3 coincident edge");
      wait_idle();
      repeat (2) @(negedge mclk);

      // Reset after activity clears everything.
      rst_n = 1'b0;
      #1;
      m_f0 = '0; m_f1 = '0; m_ph = '0;
      compare_all("R8 (reset after writes)");
      check(busy == 1'b0, "R8 (busy after reset)", 64'(busy), 64'd0);
      @(negedge mclk);
      rst_n = 1'b1;
      repeat (2) @(negedge mclk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule